// File: doc/BRIEF.md
# Funnel Shifter, 32-bit

This block shifts or rotates a 32-bit operand by 0 to 31 bit positions. It has no clock, and its result follows its inputs combinationally. All four shift kinds go through one extraction network. A front stage builds a 63-bit window from the operand and from fill bits that depend on the operation. It also picks an extraction offset. Five levels of 2:1 multiplexers then take a 32-bit slice of that window, starting at the offset.

A right shift places fill above the operand and uses the shift amount as the offset. A rotate places a second copy of the operand above the first. A left shift places the operand above a block of zeros and extracts at the complement of the amount. Because the amount is never above 31, a 63-bit window is large enough. Each multiplexer level narrows the window by the distance it shifts, so the last level is exactly 32 bits wide.

Top module: `funnel_shifter`

## Requirements
- R1: With `shift_op` = 2'b00 (logical right), `shift_res` equals `shift_src` shifted right by `shift_amt`, and zeros enter at the top.
- R2: With `shift_op` = 2'b01 (arithmetic right), `shift_res` equals `shift_src` shifted right by `shift_amt`, and copies of bit 31 of `shift_src` enter at the top.
- R3: With `shift_op` = 2'b10 (rotate right), the bits leaving at bit 0 re-enter at bit 31, so `shift_res` = (src >> amt) | (src << (32 − amt)). The number of set bits is preserved.
- R4: With `shift_op` = 2'b11 (logical left), `shift_res` equals `shift_src` shifted left by `shift_amt`, and zeros enter at the bottom.
- R5: When `shift_amt` is 0, `shift_res` equals `shift_src` for every value of `shift_op`, the left shift included.
- R6: For a non-negative operand (bit 31 clear), the arithmetic right shift gives the same result as the logical right shift.
- R7: The result depends only on the present inputs. A change on any input shows on `shift_res` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_src | input | 32 | Operand to shift or rotate |
| shift_amt | input | 5 | Shift distance, 0 to 31 |
| shift_op | input | 2 | 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| shift_res | output | 32 | Shifted result |

## Verification
Every time the inputs settle, the assertions check properties that must hold for each shift kind:
- A right shift leaves a field of zeros or of sign copies at the top.
- A rotate keeps the count of set bits.
- A left shift clears the low bits.
- A zero amount returns the operand.

These checks do not prove that the bits are placed at the right positions. Only the bench sweep can show that: it compares every operation and every amount against values computed with arithmetic, over many operand patterns. The same holds for the match between arithmetic and logical right shifts on non-negative operands, and for the purely combinational response.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
package shf_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned AMT_W  = $clog2(WORD_W);
    localparam int unsigned WIN_W  = 2 * WORD_W - 1;

    typedef enum logic [1:0] {
        SH_LSR = 2'b00,
        SH_ASR = 2'b01,
        SH_ROR = 2'b10,
        SH_LSL = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic [WIN_W-1:0] window;
        logic [AMT_W-1:0] offset;
    } funnel_sel_t;

endpackage

// File: rtl/shf_word_sel.sv
`timescale 1ns/1ps
module shf_word_sel
    import shf_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  logic [AMT_W-1:0]  amt,
    input  shift_op_e         op,
    output funnel_sel_t       sel
);

    funnel_sel_t sel_d;

    always_comb begin
        sel_d.offset = amt;
        unique case (op)
            SH_LSR: sel_d.window = {{(WORD_W-1){1'b0}}, src};
            SH_ASR: sel_d.window = {{(WORD_W-1){src[WORD_W-1]}}, src};
            SH_ROR: sel_d.window = {src[WORD_W-2:0], src};
            SH_LSL: begin
                if (amt == '0) begin
                    // offset of WORD_W is out of range: select operand directly
                    sel_d.window = {{(WORD_W-1){1'b0}}, src};
                end else begin
                    sel_d.window = {src[WORD_W-2:0], {WORD_W{1'b0}}};
                    // two's complement of amt equals WORD_W - amt in AMT_W bits
                    sel_d.offset = AMT_W'(~amt + 1'b1);
                end
            end
            default: sel_d.window = {{(WORD_W-1){1'b0}}, src};
        endcase
    end

    assign sel = sel_d;

endmodule

// File: rtl/shf_mux_level.sv
`timescale 1ns/1ps
module shf_mux_level #(
    parameter int unsigned IN_W  = 63,
    parameter int unsigned SHIFT = 16,
    localparam int unsigned OUT_W = IN_W - SHIFT
) (
    input  logic [IN_W-1:0]  lvl_in,
    input  logic             take,
    output logic [OUT_W-1:0] lvl_out
);

    logic [OUT_W-1:0] lvl_d;

    always_comb begin
        if (take) lvl_d = lvl_in[IN_W-1:SHIFT];
        else      lvl_d = lvl_in[OUT_W-1:0];
    end

    assign lvl_out = lvl_d;

endmodule

// File: rtl/shf_funnel.sv
`timescale 1ns/1ps
module shf_funnel #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned LVLS  = $clog2(WIDTH),
    localparam int unsigned WIN_W = 2 * WIDTH - 1
) (
    input  logic [WIN_W-1:0] window,
    input  logic [LVLS-1:0]  offset,
    output logic [WIDTH-1:0] slice
);

    for (genvar j = 0; j < LVLS; j++) begin : g_lvl
        localparam int unsigned SH   = WIDTH >> (j + 1);
        localparam int unsigned IW   = WIDTH - 1 + (WIDTH >> j);
        localparam int unsigned OW   = IW - SH;
        localparam int unsigned OBIT = LVLS - 1 - j;

        logic [IW-1:0] stage_in;
        logic [OW-1:0] stage_out;

        if (j == 0) begin : g_first
            assign stage_in = window;
        end else begin : g_next
            assign stage_in = g_lvl[j-1].stage_out;
        end

        shf_mux_level #(
            .IN_W (IW),
            .SHIFT(SH)
        ) u_level (
            .lvl_in (stage_in),
            .take   (offset[OBIT]),
            .lvl_out(stage_out)
        );
    end

    assign slice = g_lvl[LVLS-1].stage_out;

endmodule

// File: rtl/funnel_shifter.sv
`timescale 1ns/1ps
module funnel_shifter
    import shf_pkg::*;
(
    input  logic [31:0] shift_src,
    input  logic [4:0]  shift_amt,
    input  logic [1:0]  shift_op,
    output logic [31:0] shift_res
);

    funnel_sel_t fsel;
    shift_op_e   op_e;

    assign op_e = shift_op_e'(shift_op);

    shf_word_sel u_sel (
        .src(shift_src),
        .amt(shift_amt),
        .op (op_e),
        .sel(fsel)
    );

    shf_funnel #(
        .WIDTH(WORD_W)
    ) u_funnel (
        .window(fsel.window),
        .offset(fsel.offset),
        .slice (shift_res)
    );

    always_comb begin
        // R5
        zero_amt_chk: assert (shift_amt != '0 || shift_res == shift_src)
            else $error("zero amount changed the operand");
        // R1
        lsr_fill_chk: assert (op_e != SH_LSR || shift_amt == '0 ||
                              (shift_res >> (WORD_W - 32'(shift_amt))) == '0)
            else $error("logical right shift left ones at the top");
        // R2
        asr_sign_chk: assert (op_e != SH_ASR || shift_res[WORD_W-1] == shift_src[WORD_W-1])
            else $error("arithmetic right shift lost the sign");
        // R3
        ror_ones_chk: assert (op_e != SH_ROR || $countones(shift_res) == $countones(shift_src))
            else $error("rotate changed the number of set bits");
        // R4
        lsl_fill_chk: assert (op_e != SH_LSL || shift_amt == '0 ||
                              (shift_res << (WORD_W - 32'(shift_amt))) == '0)
            else $error("left shift left ones at the bottom");
    end

endmodule

// File: tb/funnel_shifter_test.sv
`timescale 1ns/1ps
module funnel_shifter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [4:0]  amt = '0;
    logic [1:0]  op = '0;
    logic [31:0] res;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    funnel_shifter uut (
        .shift_src(src),
        .shift_amt(amt),
        .shift_op (op),
        .shift_res(res)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s src=%h amt=%0d op=%0d actual=%h expected=%h",
                     tag, src, amt, op, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] a, input int s, input int o);
        case (o)
            0: return a >> s;
            1: return 32'($signed(a) >>> s);
            2: return (a >> s) | (a << (32 - s));
            default: return a << s;
        endcase
    endfunction

    function automatic logic [31:0] next_lfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        logic [31:0] pats [0:31];
        logic [31:0] lf;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
        pats[4] = 32'hAAAA_5555; pats[5] = 32'h7FFF_FFFF;
        pats[6] = 32'h8000_0001; pats[7] = 32'h1234_5678;
        lf = 32'hACE1_2468;
        for (int k = 8; k < 32; k++) begin
            lf = next_lfsr(next_lfsr(next_lfsr(lf)));
            pats[k] = lf;
        end

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset-state zero input", res, 32'h0);

        for (int p = 0; p < 32; p++) begin
            for (int o = 0; o < 4; o++) begin
                for (int s = 0; s < 32; s++) begin
                    @(posedge clk); #1;
                    src = pats[p]; amt = 5'(s); op = 2'(o);
                    @(negedge clk);
                    case (o)
                        0: check("R1 logical right", res, model(pats[p], s, 0));
                        1: check("R2 arithmetic right", res, model(pats[p], s, 1));
                        2: check("R3 rotate right", res, model(pats[p], s, 2));
                        default: check("R4 logical left", res, model(pats[p], s, 3));
                    endcase
                    if (s == 0) check("R5 zero amount", res, pats[p]);
                    if (o == 1 && !pats[p][31])
                        check("R6 asr equals lsr", res, pats[p] >> s);
                end
            end
        end

        // R7: inputs change with no clock edge in between
        @(negedge clk);
        src = 32'hF000_000F; amt = 5'd4; op = 2'b11; #0.5;
        check("R7 comb left", res, 32'h0000_00F0);
        op = 2'b10; #0.5;
        check("R7 comb rotate", res, 32'hFF00_0000);
        amt = 5'd31; op = 2'b01; #0.5;
        check("R7 comb arith", res, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule